// File: doc/BRIEF.md
# Multi-Channel PWM with Comparator Cycle Blanking

This block produces several pulse-width-modulated outputs from one shared period counter. An external comparator signal, arriving asynchronously, can blank any enabled channel. The chosen comparator edge forces that channel low for the rest of the running period. This gives cycle-by-cycle current limiting: once the sensed current crosses its threshold, the drive pulse ends early and restarts with the next period.

The period length comes from a resolution code. Each channel has its own compare value and its own blanking enable. A single polarity bit selects which comparator edge blanks the output. If the comparator still sits at its post-edge level when a new period starts, the blanking carries over into that period. Compare values and the resolution code are captured into shadow copies only at the counter wrap, so every period runs with one consistent setting.

Top module: `pwm_cmp_blank`

## Requirements
- R1: The counter runs from 0 up to a limit set by the resolution code and then returns to 0. The limits are: code 0 gives 255, code 1 gives 511, code 2 gives 1023, code 3 gives 2047, and codes 4 to 7 give 65535. `period_start_o` is high exactly while the counter holds 0.
- R2: Before blanking, a channel is high while the counter is below its compare value and low otherwise. A compare value of 0 gives a constant low output. A compare value above the limit gives a constant high output. The output register delays this by one clock.
- R3: The comparator passes through a two-flop synchronizer and an edge-detect flop. A blanking edge sampled at clock edge k drives the enabled output low at clock edge k+3.
- R4: A channel whose blank-enable bit is 0 follows the plain waveform of R2, whatever the comparator does.
- R5: With polarity 0, a falling comparator edge blanks the channel. With polarity 1, a rising edge blanks it. The opposite edge does not blank.
- R6: Once blanked, an enabled channel stays low until the period ends. It is released at the next period start if the synchronized comparator is then away from its active level.
- R7: If the synchronized comparator is at its active level at a period start, an enabled channel is blanked for that whole period. The active level is low for polarity 0 and high for polarity 1.
- R8: Changes to a compare value or to the resolution code take effect only from the first count of the next period.
- R9: Reset clears all of the following: the counter, the outputs, the blanking state and the compare shadows. It also sets the limit to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_async_i | input | 1 | Comparator output, asynchronous to clk_i |
| blank_en_i | input | N_CH | Per-channel blanking enable |
| blank_pol_i | input | 1 | 0: falling edge blanks, 1: rising edge blanks |
| res_sel_i | input | 3 | Resolution code (see R1) |
| cmp_val_i | input | N_CH*16 | Compare values, channel c in bits [16c+15:16c] |
| pwm_o | output | N_CH | Registered channel outputs |
| period_start_o | output | 1 | High while the counter holds 0 |

## Verification
The bench sends comparator edges in the middle of a period and checks the output on the exact clock, so an extra or missing synchronizer stage shows up as a one-cycle mismatch. It holds the comparator at the active level across a wrap to catch a design that forgets to re-blank. It also lets the comparator return before the wrap to catch a design that never releases. Compare values and the resolution code are changed in the middle of a period, which exposes a design that applies them at once instead of at the wrap. Compare values of 0 and above the limit exercise the constant-low and constant-high ends of the waveform.

// File: rtl/pwmcb_pkg.sv
package pwmcb_pkg;
   localparam int CW = 16;
   typedef logic [CW-1:0] cnt_t;

   function automatic cnt_t limit_for(input logic [2:0] code);
      case (code)
         3'd0:    return cnt_t'(255);
         3'd1:    return cnt_t'(511);
         3'd2:    return cnt_t'(1023);
         3'd3:    return cnt_t'(2047);
         default: return cnt_t'(65535);
      endcase
   endfunction
endpackage

// File: rtl/pwmcb_timebase.sv
module pwmcb_timebase
   import pwmcb_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] res_sel_i,
   output cnt_t       cnt_o,
   output logic       wrap_o,
   output logic       start_o
);
   cnt_t cnt_q, lim_q;

   assign wrap_o  = (cnt_q == lim_q);
   assign start_o = (cnt_q == '0);
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         lim_q <= limit_for(3'd0);
      end else if (wrap_o) begin
         cnt_q <= '0;
         lim_q <= limit_for(res_sel_i);
      end else begin
         cnt_q <= cnt_q + cnt_t'(1);
      end
   end

   assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= lim_q);
   assert_wrap_returns_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> (cnt_q == '0));
   assert_limit_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap_o |=> $stable(lim_q));
endmodule

// File: rtl/pwmcb_cmp_sync.sv
module pwmcb_cmp_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cmp_async_i,
   input  logic pol_i,
   output logic active_o,
   output logic trig_o
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] pipe_q;
   logic                   prev_q;
   logic                   lvl, rise, fall;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pipe_q <= '0;
         prev_q <= 1'b0;
      end else begin
         pipe_q <= {pipe_q[SYNC_STAGES-2:0], cmp_async_i};
         prev_q <= pipe_q[SYNC_STAGES-1];
      end
   end

   assign lvl      = pipe_q[SYNC_STAGES-1];
   assign rise     = lvl & ~prev_q;
   assign fall     = ~lvl & prev_q;
   assign active_o = pol_i ? lvl : ~lvl;
   assign trig_o   = pol_i ? rise : fall;

   assert_edges_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({rise, fall}));
   assert_trig_implies_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o |-> active_o);
endmodule

// File: rtl/pwmcb_chan.sv
module pwmcb_chan
   import pwmcb_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  cnt_t cnt_i,
   input  logic wrap_i,
   input  cnt_t cmp_val_i,
   input  logic en_i,
   input  logic active_i,
   input  logic trig_i,
   output logic pwm_o
);
   cnt_t shadow_q;
   logic blank_q, pwm_q, raw;

   assign raw   = (cnt_i < shadow_q);
   assign pwm_o = pwm_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         shadow_q <= '0;
         blank_q  <= 1'b0;
         pwm_q    <= 1'b0;
      end else begin
         pwm_q <= raw & ~(blank_q & en_i);
         if (wrap_i) begin
            shadow_q <= cmp_val_i;
            blank_q  <= en_i & active_i;
         end else if (en_i & trig_i) begin
            blank_q  <= 1'b1;
         end
      end
   end

   assert_shadow_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap_i |=> $stable(shadow_q));
   assert_blank_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blank_q && !wrap_i) |=> blank_q);
   assert_blank_forces_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blank_q && en_i) |=> !pwm_q);
   assert_plain_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (pwm_q == $past(raw)));
endmodule

// File: rtl/pwm_cmp_blank.sv
module pwm_cmp_blank
   import pwmcb_pkg::*;
#(
   parameter int N_CH        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 cmp_async_i,
   input  logic [N_CH-1:0]      blank_en_i,
   input  logic                 blank_pol_i,
   input  logic [2:0]           res_sel_i,
   input  logic [N_CH*CW-1:0]   cmp_val_i,
   output logic [N_CH-1:0]      pwm_o,
   output logic                 period_start_o
);
   if (N_CH < 1) begin : g_bad_nch
      $error("N_CH must be at least 1");
   end

   cnt_t cnt;
   logic wrap, active, trig;

   pwmcb_timebase u_tb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .res_sel_i (res_sel_i),
      .cnt_o     (cnt),
      .wrap_o    (wrap),
      .start_o   (period_start_o)
   );

   pwmcb_cmp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmp_async_i (cmp_async_i),
      .pol_i       (blank_pol_i),
      .active_o    (active),
      .trig_o      (trig)
   );

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      pwmcb_chan u_ch (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .cnt_i     (cnt),
         .wrap_i    (wrap),
         .cmp_val_i (cmp_val_i[g*CW +: CW]),
         .en_i      (blank_en_i[g]),
         .active_i  (active),
         .trig_i    (trig),
         .pwm_o     (pwm_o[g])
      );
   end

   assert_start_is_first_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap |=> period_start_o);
endmodule

// File: tb/sim_pwm_cmp_blank.sv
`timescale 1ns/1ps
module sim_pwm_cmp_blank;
   localparam int N = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmp_async = 1'b1;
   logic [N-1:0]  en = '0;
   logic          pol = 1'b0;
   logic [2:0]    res = 3'd0;
   logic [N*16-1:0] cmp_val = '0;
   logic [N-1:0]  pwm;
   logic          pstart;

   always #2.5 clk = ~clk;

   pwm_cmp_blank #(.N_CH(N)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .cmp_async_i(cmp_async),
      .blank_en_i(en), .blank_pol_i(pol), .res_sel_i(res),
      .cmp_val_i(cmp_val), .pwm_o(pwm), .period_start_o(pstart)
   );

   int    checks = 0, failures = 0, wd = 0;
   bit    done = 0;
   string tag = "R9";

   // behavioural reference model
   int m_cnt = 0, m_lim = 255;
   int m_cmp[N];
   bit m_blank[N];
   bit m_out[N];
   bit hist[$] = '{0, 0, 0};
   bit s_new, s_old, act, trig, wrap;

   function automatic int lim_of(input logic [2:0] c);
      case (c)
         3'd0: return 255;
         3'd1: return 511;
         3'd2: return 1023;
         3'd3: return 2047;
         default: return 65535;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_lim = 255;
         for (int c = 0; c < N; c++) begin m_cmp[c] = 0; m_blank[c] = 0; m_out[c] = 0; end
         hist = '{0, 0, 0};
      end else begin
         s_new = hist[1]; s_old = hist[2];
         act  = pol ? s_new : !s_new;
         trig = pol ? (s_new && !s_old) : (!s_new && s_old);
         wrap = (m_cnt == m_lim);
         for (int c = 0; c < N; c++) begin
            m_out[c] = (m_cnt < m_cmp[c]) && !(m_blank[c] && en[c]);
            if (wrap) m_blank[c] = en[c] && act;
            else if (en[c] && trig) m_blank[c] = 1;
            if (wrap) m_cmp[c] = int'(cmp_val[c*16 +: 16]);
         end
         if (wrap) begin m_cnt = 0; m_lim = lim_of(res); end
         else m_cnt++;
         hist.push_front(cmp_async);
         void'(hist.pop_back());
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act_v, input int exp_v);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int c = 0; c < N; c++)
            check(pwm[c] === m_out[c], tag, $sformatf("pwm ch%0d cnt %0d", c, m_cnt),
                  int'(pwm[c]), int'(m_out[c]));
         check(pstart === (m_cnt == 0), "R1", "period_start", int'(pstart), int'(m_cnt == 0));
      end
   end

   always @(negedge clk) begin
      wd++;
      if (wd > 200000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog R1: actual %0d expected %0d", wd, 200000);
         report();
         $finish;
      end
   end

   task automatic wait_cnt(input int k);
      do @(negedge clk); while (m_cnt != k);
   endtask

   task automatic set_cmp(input int c, input int v);
      cmp_val[c*16 +: 16] = 16'(v);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check(pwm === '0, "R9", "pwm in reset", int'(pwm), 0);
      check(pstart === 1'b1, "R9", "period_start in reset", int'(pstart), 1);
      rst_n = 1'b1;

      // R2: plain waveform, constant low / constant high ends
      tag = "R2";
      set_cmp(0, 0); set_cmp(1, 100); set_cmp(2, 255); set_cmp(3, 300);
      repeat (600) @(negedge clk);

      // R4: blanking disabled, comparator toggling
      tag = "R4";
      for (int i = 0; i < 12; i++) begin
         repeat (37) @(negedge clk);
         cmp_async = ~cmp_async;
      end
      cmp_async = 1'b1;
      for (int c = 0; c < N; c++) set_cmp(c, 200);
      wait_cnt(0);

      // R3: single falling edge mid-period, exact latency
      tag = "R3"; en = '1; pol = 1'b0;
      wait_cnt(0);
      wait_cnt(40);  cmp_async = 1'b0;
      wait_cnt(120); cmp_async = 1'b1;
      wait_cnt(0);

      // R5: polarity 1, rising edge blanks, falling does not
      tag = "R5"; cmp_async = 1'b0; pol = 1'b1;
      wait_cnt(0);
      wait_cnt(60);  cmp_async = 1'b1;
      wait_cnt(100); cmp_async = 1'b0;
      wait_cnt(0);
      wait_cnt(30);  cmp_async = 1'b1;
      wait_cnt(31);  cmp_async = 1'b0;
      wait_cnt(0);

      // R6: blank then release at next period, mixed enables
      tag = "R6"; pol = 1'b0; cmp_async = 1'b1; en = 4'b0101;
      wait_cnt(0);
      wait_cnt(30); cmp_async = 1'b0;
      wait_cnt(50); cmp_async = 1'b1;
      wait_cnt(0);
      wait_cnt(0);

      // R7: comparator held active across the wrap
      tag = "R7"; en = '1; set_cmp(0, 250);
      wait_cnt(200); cmp_async = 1'b0;
      wait_cnt(0);
      wait_cnt(100); cmp_async = 1'b1;
      wait_cnt(0);
      pol = 1'b1;
      wait_cnt(0);
      pol = 1'b0;
      wait_cnt(0);

      // R8: mid-period changes of compare and resolution
      tag = "R8";
      wait_cnt(100);
      set_cmp(0, 30); set_cmp(1, 240); set_cmp(3, 400); res = 3'd1;
      repeat (1100) @(negedge clk);
      res = 3'd2;
      repeat (2200) @(negedge clk);
      res = 3'd3;
      repeat (4200) @(negedge clk);

      // R1: widest resolution
      tag = "R1"; res = 3'd4; set_cmp(2, 60000);
      repeat (70000) @(negedge clk);

      done = 1;
      report();
      $finish;
   end
endmodule